// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block turns one write to a command register into a series of master operations on an I2C bus. The operations are always taken in the same order: address phase (with start or repeated start), data transmit, data receive, and stop. A single write may ask for any subset of them. The block does not toggle SCL or SDA itself. It hands each stage to a byte-level bus engine through a request/done handshake. The engine can issue a start with a 7-bit address and a read/write bit, send a byte, receive a byte (with an optional NAK for the last byte), or end the transfer.

The sequencer keeps a 4-bit state field that records whether a transfer is open on the bus. A start issued while a transfer is open becomes a repeated start. A stop issued while no transfer is open is reported as abnormal. Each command bit clears itself when its stage finishes. Outcomes are reported as one-cycle event pulses. A received byte leaves a receive-done flag set, and that flag holds off further receives until it is cleared.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: After reset, the status word is zero, busy is low, rxPending is low, no engine request is raised and no event pulses.
- R2: A command write is ignored when master enable is clear or when busy is high. Master enable is written through ctlWrEn/ctlMasterEn. An ignored write raises no engine request and leaves the status word unchanged.
- R3: The requested stages run in this order: start (command bit 0), transmit (bit 1), receive (bit 3 or bit 4), stop (bit 5). Each stage holds engReq high with a stable engOp until engDone is seen. engOp encodings are start=0, send=1, receive=2, end=3.
- R4: During the start stage the state field (status bits 22:19) reads 0xA when bit 3 of the state field was set before the stage, and 0x9 otherwise. engAddr carries address byte bits 7:1 and engRead carries bit 0. If the engine acknowledges, evTxAck pulses, the state field becomes 0x8 and bit 0 clears.
- R5: If the address is not acknowledged, evTxNak pulses and command bits 0, 1, 3, 4 and 5 all clear. No further engine request follows, and the state field keeps the start code.
- R6: During transmit the state field reads 0xC. An ACK pulses evTxAck. A NAK pulses evTxNak and is followed by an end request (op 3). In both cases bit 1 clears and the state field returns to 0x8.
- R7: A receive runs only when bit 3 or bit 4 is set and rxPending is low. During it the state field reads 0xE and engNackLast equals bit 4. On completion the received byte appears on rxByte, rxPending is set, evRxDone pulses, bits 3 and 4 clear and the state field returns to 0x8. When rxPending is high the receive is skipped and bits 3 and 4 stay set.
- R8: A stop with bit 3 of the state field set shows state 0xB, requests an end (op 3) and pulses evNormStop. A stop with that bit clear pulses evAbnormal and makes no engine request. Both cases clear bit 5 and set the state field to 0x0.
- R9: busy rises on the edge that accepts a command and falls after the last stage completes. engReq is never high while busy is low. At most one event pulses in any cycle.
- R10: A pulse on rxPendClr clears rxPending, which lets the next receive run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWrEn | input | 1 | Write strobe for master enable |
| ctlMasterEn | input | 1 | Master enable value |
| cmdWrEn | input | 1 | Command write strobe |
| cmdWrData | input | 16 | Command bits written to status bits 15:0 |
| addrByte | input | 8 | Target address (7:1) and read flag (0) |
| txByte | input | 8 | Byte sent by the transmit stage |
| rxPendClr | input | 1 | Clears the receive-done flag |
| engDone | input | 1 | Engine stage completion pulse |
| engAck | input | 1 | Engine result valid with engDone: 1 = ACK |
| engRxData | input | 8 | Byte received by the engine, valid with engDone |
| engReq | output | 1 | Engine stage request, held until engDone |
| engOp | output | 2 | Engine operation code |
| engAddr | output | 7 | Target address for a start |
| engRead | output | 1 | Read/write flag for a start |
| engData | output | 8 | Byte to send |
| engNackLast | output | 1 | NAK the received byte |
| cmdStatus | output | 32 | State field at 22:19, command bits at 15:0 |
| busy | output | 1 | Sequence in progress |
| rxPending | output | 1 | Receive-done flag |
| rxByte | output | 8 | Last received byte |
| evTxAck | output | 1 | Address or data acknowledged |
| evTxNak | output | 1 | Address or data not acknowledged |
| evRxDone | output | 1 | Receive finished |
| evNormStop | output | 1 | Stop issued on an open transfer |
| evAbnormal | output | 1 | Stop requested with no open transfer |

## Verification
The sequencer is tried with a command that asks for all four stages, with single-stage commands for start, transmit and stop, and with a start plus receive-last command. Comparing the recorded engine operations and the state field seen at each request shows whether the ordering and the start versus repeated-start choice are right. A command sent with a NAKed address, one with a NAKed data byte, a stop sent with no transfer open, a receive sent while receive-done is pending, and writes sent while disabled or busy each test one branch that a sequencer which never checks outcomes would get wrong. A slow engine response stretches busy, so a second write can land while the block is running.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_END   = 2'd3
  } engOp_e;

  // state field codes; bit 3 marks an open transfer
  localparam logic [3:0] SC_IDLE    = 4'h0;
  localparam logic [3:0] SC_ACTIVE  = 4'h8;
  localparam logic [3:0] SC_START   = 4'h9;
  localparam logic [3:0] SC_RESTART = 4'hA;
  localparam logic [3:0] SC_STOP    = 4'hB;
  localparam logic [3:0] SC_TXD     = 4'hC;
  localparam logic [3:0] SC_RXD     = 4'hE;

  // command bit positions inside the low half of the status word
  localparam int CB_START = 0;
  localparam int CB_TX    = 1;
  localparam int CB_RX    = 3;
  localparam int CB_LAST  = 4;
  localparam int CB_STOP  = 5;

  typedef struct packed {
    logic       setState;
    logic [3:0] stateVal;
    logic       clrStart;
    logic       clrTx;
    logic       clrRx;
    logic       clrStop;
    logic       clrAll;
    logic       loadRx;
    logic       evAck;
    logic       evNak;
    logic       evRx;
    logic       evNorm;
    logic       evAbn;
  } seqStrobe_t;

endpackage

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdAccept,
  input  logic       startBit,
  input  logic       txBit,
  input  logic       rxBit,
  input  logic       lastBit,
  input  logic       stopBit,
  input  logic       activeBit,
  input  logic       rxPend,
  input  logic       engDone,
  input  logic       engAck,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       engReq,
  output engOp_e     engOp
);

  typedef enum logic [2:0] {
    C_IDLE, C_DISP, C_START, C_TX, C_TXEND, C_RX, C_STOP
  } ctrlState_e;

  ctrlState_e cur, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cur <= C_IDLE;
    else       cur <= nxt;
  end

  always_comb begin
    strb = '0;
    nxt  = cur;
    unique case (cur)
      C_IDLE: if (cmdAccept) nxt = C_DISP;
      C_DISP: begin
        if (startBit) begin
          strb.setState = 1'b1;
          strb.stateVal = activeBit ? SC_RESTART : SC_START;
          nxt = C_START;
        end else if (txBit) begin
          strb.setState = 1'b1;
          strb.stateVal = SC_TXD;
          nxt = C_TX;
        end else if ((rxBit || lastBit) && !rxPend) begin
          strb.setState = 1'b1;
          strb.stateVal = SC_RXD;
          nxt = C_RX;
        end else if (stopBit) begin
          strb.setState = 1'b1;
          if (activeBit) begin
            strb.stateVal = SC_STOP;
            nxt = C_STOP;
          end else begin
            strb.stateVal = SC_IDLE;
            strb.evAbn    = 1'b1;
            strb.clrStop  = 1'b1;
          end
        end else begin
          nxt = C_IDLE;
        end
      end
      C_START: if (engDone) begin
        if (engAck) begin
          strb.setState = 1'b1;
          strb.stateVal = SC_ACTIVE;
          strb.evAck    = 1'b1;
          strb.clrStart = 1'b1;
          nxt = C_DISP;
        end else begin
          strb.evNak  = 1'b1;
          strb.clrAll = 1'b1;
          nxt = C_IDLE;
        end
      end
      C_TX: if (engDone) begin
        strb.setState = 1'b1;
        strb.stateVal = SC_ACTIVE;
        strb.clrTx    = 1'b1;
        strb.evAck    = engAck;
        strb.evNak    = !engAck;
        nxt = engAck ? C_DISP : C_TXEND;
      end
      C_TXEND: if (engDone) nxt = C_DISP;
      C_RX: if (engDone) begin
        strb.setState = 1'b1;
        strb.stateVal = SC_ACTIVE;
        strb.loadRx   = 1'b1;
        strb.evRx     = 1'b1;
        strb.clrRx    = 1'b1;
        nxt = C_DISP;
      end
      C_STOP: if (engDone) begin
        strb.setState = 1'b1;
        strb.stateVal = SC_IDLE;
        strb.evNorm   = 1'b1;
        strb.clrStop  = 1'b1;
        nxt = C_DISP;
      end
      default: nxt = C_IDLE;
    endcase
  end

  assign busy   = (cur != C_IDLE);
  assign engReq = (cur == C_START) || (cur == C_TX) || (cur == C_TXEND) ||
                  (cur == C_RX) || (cur == C_STOP);

  always_comb begin
    unique case (cur)
      C_START: engOp = OP_START;
      C_TX:    engOp = OP_SEND;
      C_RX:    engOp = OP_RECV;
      default: engOp = OP_END;
    endcase
  end

endmodule

// File: rtl/i2c_seq_dp.sv
module i2c_seq_dp
  import i2c_seq_pkg::*;
#(
  parameter int CMD_W     = 32,
  parameter int CMD_LOW_W = 16,
  parameter int ST_LSB    = 19,
  parameter int BYTE_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctlWrEn,
  input  logic                 ctlMasterEn,
  input  logic                 cmdAccept,
  input  logic [CMD_LOW_W-1:0] cmdWrData,
  input  logic                 rxPendClr,
  input  logic [BYTE_W-1:0]    engRxData,
  input  seqStrobe_t           strb,
  output logic                 masterEn,
  output logic [CMD_LOW_W-1:0] cmdBits,
  output logic [3:0]           stateCode,
  output logic                 rxPend,
  output logic [BYTE_W-1:0]    rxByte,
  output logic [4:0]           events,
  output logic [CMD_W-1:0]     cmdStatus
);

  localparam logic [CMD_LOW_W-1:0] OP_MASK =
    CMD_LOW_W'((1 << CB_START) | (1 << CB_TX) | (1 << CB_RX) |
               (1 << CB_LAST) | (1 << CB_STOP));

  logic [CMD_LOW_W-1:0] clrMask;

  always_comb begin
    clrMask = '0;
    if (strb.clrAll)   clrMask = OP_MASK;
    if (strb.clrStart) clrMask[CB_START] = 1'b1;
    if (strb.clrTx)    clrMask[CB_TX]    = 1'b1;
    if (strb.clrRx) begin
      clrMask[CB_RX]   = 1'b1;
      clrMask[CB_LAST] = 1'b1;
    end
    if (strb.clrStop)  clrMask[CB_STOP]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterEn  <= 1'b0;
      cmdBits   <= '0;
      stateCode <= SC_IDLE;
      rxPend    <= 1'b0;
      rxByte    <= '0;
      events    <= '0;
    end else begin
      if (ctlWrEn) masterEn <= ctlMasterEn;
      if (cmdAccept) cmdBits <= cmdWrData;
      else           cmdBits <= cmdBits & ~clrMask;
      if (strb.setState) stateCode <= strb.stateVal;
      if (strb.evRx)        rxPend <= 1'b1;
      else if (rxPendClr)   rxPend <= 1'b0;
      if (strb.loadRx) rxByte <= engRxData;
      events <= {strb.evAbn, strb.evNorm, strb.evRx, strb.evNak, strb.evAck};
    end
  end

  always_comb begin
    cmdStatus = '0;
    cmdStatus[CMD_LOW_W-1:0] = cmdBits;
    cmdStatus[ST_LSB +: 4]   = stateCode;
  end

endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer
  import i2c_seq_pkg::*;
#(
  parameter int CMD_W     = 32,
  parameter int CMD_LOW_W = 16,
  parameter int ST_LSB    = 19,
  parameter int BYTE_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctlWrEn,
  input  logic                 ctlMasterEn,
  input  logic                 cmdWrEn,
  input  logic [CMD_LOW_W-1:0] cmdWrData,
  input  logic [BYTE_W-1:0]    addrByte,
  input  logic [BYTE_W-1:0]    txByte,
  input  logic                 rxPendClr,
  input  logic                 engDone,
  input  logic                 engAck,
  input  logic [BYTE_W-1:0]    engRxData,
  output logic                 engReq,
  output logic [1:0]           engOp,
  output logic [BYTE_W-2:0]    engAddr,
  output logic                 engRead,
  output logic [BYTE_W-1:0]    engData,
  output logic                 engNackLast,
  output logic [CMD_W-1:0]     cmdStatus,
  output logic                 busy,
  output logic                 rxPending,
  output logic [BYTE_W-1:0]    rxByte,
  output logic                 evTxAck,
  output logic                 evTxNak,
  output logic                 evRxDone,
  output logic                 evNormStop,
  output logic                 evAbnormal
);

  seqStrobe_t           strb;
  engOp_e               opE;
  logic                 masterEn;
  logic                 cmdAccept;
  logic [CMD_LOW_W-1:0] cmdBits;
  logic [3:0]           stateCode;
  logic [4:0]           events;

  assign cmdAccept = cmdWrEn && masterEn && !busy;

  i2c_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdAccept (cmdAccept),
    .startBit  (cmdBits[CB_START]),
    .txBit     (cmdBits[CB_TX]),
    .rxBit     (cmdBits[CB_RX]),
    .lastBit   (cmdBits[CB_LAST]),
    .stopBit   (cmdBits[CB_STOP]),
    .activeBit (stateCode[3]),
    .rxPend    (rxPending),
    .engDone   (engDone),
    .engAck    (engAck),
    .strb      (strb),
    .busy      (busy),
    .engReq    (engReq),
    .engOp     (opE)
  );

  i2c_seq_dp #(
    .CMD_W(CMD_W), .CMD_LOW_W(CMD_LOW_W), .ST_LSB(ST_LSB), .BYTE_W(BYTE_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctlWrEn     (ctlWrEn),
    .ctlMasterEn (ctlMasterEn),
    .cmdAccept   (cmdAccept),
    .cmdWrData   (cmdWrData),
    .rxPendClr   (rxPendClr),
    .engRxData   (engRxData),
    .strb        (strb),
    .masterEn    (masterEn),
    .cmdBits     (cmdBits),
    .stateCode   (stateCode),
    .rxPend      (rxPending),
    .rxByte      (rxByte),
    .events      (events),
    .cmdStatus   (cmdStatus)
  );

  assign engOp       = opE;
  assign engAddr     = addrByte[BYTE_W-1:1];
  assign engRead     = addrByte[0];
  assign engData     = txByte;
  assign engNackLast = cmdBits[CB_LAST];

  assign {evAbnormal, evNormStop, evRxDone, evTxNak, evTxAck} = events;

endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk #(
  parameter int CMD_W  = 32,
  parameter int ST_LSB = 19
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             engReq,
  input logic [1:0]       engOp,
  input logic             engDone,
  input logic [CMD_W-1:0] cmdStatus,
  input logic             rxPending,
  input logic             evTxAck,
  input logic             evTxNak,
  input logic             evRxDone,
  input logic             evNormStop,
  input logic             evAbnormal
);

  logic [3:0] st;
  assign st = cmdStatus[ST_LSB +: 4];

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !engReq);  // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    engReq && !engDone |=> engReq && $stable(engOp));  // R3
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evTxAck, evTxNak, evRxDone, evNormStop, evAbnormal}));  // R9
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (evNormStop || evAbnormal) |-> (st == 4'h0) && !cmdStatus[5]);  // R8
  AST_START_CODE: assert property (@(posedge clk) disable iff (!rstN)
    engReq && engOp == 2'd0 |-> (st == 4'h9) || (st == 4'hA));  // R4
  AST_TX_CODE: assert property (@(posedge clk) disable iff (!rstN)
    engReq && engOp == 2'd1 |-> st == 4'hC);  // R6
  AST_RX_CODE: assert property (@(posedge clk) disable iff (!rstN)
    engReq && engOp == 2'd2 |-> st == 4'hE);  // R7
  AST_RX_PEND: assert property (@(posedge clk) disable iff (!rstN)
    evRxDone |-> rxPending);  // R7

endmodule

bind i2c_cmd_sequencer i2c_seq_chk #(.CMD_W(CMD_W), .ST_LSB(ST_LSB)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .engReq     (engReq),
  .engOp      (engOp),
  .engDone    (engDone),
  .cmdStatus  (cmdStatus),
  .rxPending  (rxPending),
  .evTxAck    (evTxAck),
  .evTxNak    (evTxNak),
  .evRxDone   (evRxDone),
  .evNormStop (evNormStop),
  .evAbnormal (evAbnormal)
);

// File: tb/i2c_cmd_sequencer_tb.sv
`timescale 1ns/1ps
module i2c_cmd_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0, ctlMasterEn = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [15:0] cmdWrData = '0;
  logic [7:0]  addrByte = '0, txByte = '0;
  logic        rxPendClr = 1'b0;
  logic        engDone = 1'b0, engAck = 1'b0;
  logic [7:0]  engRxData = '0;
  logic        engReq;
  logic [1:0]  engOp;
  logic [6:0]  engAddr;
  logic        engRead, engNackLast;
  logic [7:0]  engData;
  logic [31:0] cmdStatus;
  logic        busy, rxPending;
  logic [7:0]  rxByte;
  logic        evTxAck, evTxNak, evRxDone, evNormStop, evAbnormal;

  always #5 clk = ~clk;

  i2c_cmd_sequencer dut_i (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlMasterEn(ctlMasterEn),
    .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData), .addrByte(addrByte),
    .txByte(txByte), .rxPendClr(rxPendClr), .engDone(engDone),
    .engAck(engAck), .engRxData(engRxData), .engReq(engReq), .engOp(engOp),
    .engAddr(engAddr), .engRead(engRead), .engData(engData),
    .engNackLast(engNackLast), .cmdStatus(cmdStatus), .busy(busy),
    .rxPending(rxPending), .rxByte(rxByte), .evTxAck(evTxAck),
    .evTxNak(evTxNak), .evRxDone(evRxDone), .evNormStop(evNormStop),
    .evAbnormal(evAbnormal)
  );

  int total = 0, bad = 0;
  // engine model knobs
  int   engDly = 3;
  logic addrAckV = 1'b1, txAckV = 1'b1;
  logic [7:0] rxVal = 8'h00;
  // request log
  int         nOps = 0;
  logic [1:0] opLog   [8];
  logic [6:0] addrLog [8];
  logic       readLog [8];
  logic       nackLog [8];
  logic [3:0] stLog   [8];
  logic [7:0] dataLog [8];
  int nAck = 0, nNak = 0, nRx = 0, nNorm = 0, nAbn = 0;
  logic busyAfter;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  // byte engine model, driven away from the active edge
  initial forever begin
    @(negedge clk);
    if (engReq) begin
      logic [1:0] op;
      op = engOp;
      if (nOps < 8) begin
        opLog[nOps] = engOp; addrLog[nOps] = engAddr; readLog[nOps] = engRead;
        nackLog[nOps] = engNackLast; stLog[nOps] = cmdStatus[22:19];
        dataLog[nOps] = engData;
      end
      nOps++;
      repeat (engDly) @(negedge clk);
      engAck    = (op == 2'd0) ? addrAckV : txAckV;
      engRxData = rxVal;
      engDone   = 1'b1;
      @(negedge clk);
      engDone   = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (evTxAck)    nAck++;
    if (evTxNak)    nNak++;
    if (evRxDone)   nRx++;
    if (evNormStop) nNorm++;
    if (evAbnormal) nAbn++;
  end

  task automatic clearLog();
    @(posedge clk);
    nOps = 0; nAck = 0; nNak = 0; nRx = 0; nNorm = 0; nAbn = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!busy && !engDone) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic issue(input logic [15:0] cmd);
    clearLog();
    @(negedge clk);
    cmdWrEn = 1'b1; cmdWrData = cmd;
    @(negedge clk);
    cmdWrEn = 1'b0;
    busyAfter = busy;
    waitIdle();
  endtask

  task automatic t_reset();
    chkEq("R1 status", cmdStatus, 32'h0);
    chkEq("R1 busy", busy, 0);
    chkEq("R1 req", engReq, 0);
    chkEq("R1 rxPending", rxPending, 0);
    chkEq("R1 events", {evTxAck, evTxNak, evRxDone, evNormStop, evAbnormal}, 0);
  endtask

  task automatic t_disabled();
    issue(16'h0021);
    chkEq("R2 disabled busy", busyAfter, 0);
    chkEq("R2 disabled ops", nOps, 0);
    chkEq("R2 disabled status", cmdStatus, 32'h0);
  endtask

  task automatic t_chain();
    addrByte = 8'hA5; txByte = 8'h3C; rxVal = 8'h96;
    issue(16'h002B);
    chkEq("R9 busy after write", busyAfter, 1);
    chkEq("R3 op count", nOps, 4);
    chkEq("R3 order", {opLog[0], opLog[1], opLog[2], opLog[3]}, 8'b00_01_10_11);
    chkEq("R4 address", addrLog[0], 7'h52);
    chkEq("R4 read flag", readLog[0], 1);
    chkEq("R4 start code", stLog[0], 4'h9);
    chkEq("R6 tx code", stLog[1], 4'hC);
    chkEq("R6 tx byte", dataLog[1], 8'h3C);
    chkEq("R7 rx code", stLog[2], 4'hE);
    chkEq("R7 no nack", nackLog[2], 0);
    chkEq("R8 stop code", stLog[3], 4'hB);
    chkEq("R4 ack count", nAck, 2);
    chkEq("R7 rx done", nRx, 1);
    chkEq("R8 normal stop", nNorm, 1);
    chkEq("R8 final status", cmdStatus, 32'h0);
    chkEq("R7 rx byte", rxByte, 8'h96);
    chkEq("R7 pending", rxPending, 1);
  endtask

  task automatic t_rxSkip();
    issue(16'h0011);
    chkEq("R7 skip ops", nOps, 1);
    chkEq("R7 skip rx done", nRx, 0);
    chkEq("R7 skip status", cmdStatus, 32'h0040_0010);
  endtask

  task automatic t_rxClr();
    @(negedge clk); rxPendClr = 1'b1;
    @(negedge clk); rxPendClr = 1'b0;
    chkEq("R10 pending cleared", rxPending, 0);
    rxVal = 8'h5A;
    issue(16'h0010);
    chkEq("R10 rx ran", nOps, 1);
    chkEq("R7 op recv", opLog[0], 2'd2);
    chkEq("R7 nack last", nackLog[0], 1);
    chkEq("R7 rx byte 2", rxByte, 8'h5A);
    chkEq("R7 status after rx", cmdStatus, 32'h0040_0000);
  endtask

  task automatic t_restart();
    issue(16'h0001);
    chkEq("R4 restart ops", nOps, 1);
    chkEq("R4 restart code", stLog[0], 4'hA);
    chkEq("R4 restart ack", nAck, 1);
    chkEq("R4 restart status", cmdStatus, 32'h0040_0000);
  endtask

  task automatic t_busyIgnore();
    engDly = 20;
    clearLog();
    @(negedge clk); cmdWrEn = 1'b1; cmdWrData = 16'h0002;
    @(negedge clk); cmdWrEn = 1'b0;
    @(negedge clk); cmdWrEn = 1'b1; cmdWrData = 16'h0021;
    @(negedge clk); cmdWrEn = 1'b0;
    waitIdle();
    engDly = 3;
    chkEq("R2 busy write ops", nOps, 1);
    chkEq("R2 busy write op", opLog[0], 2'd1);
    chkEq("R2 busy write status", cmdStatus, 32'h0040_0000);
  endtask

  task automatic t_txNak();
    txAckV = 1'b0;
    issue(16'h0002);
    txAckV = 1'b1;
    chkEq("R6 nak ops", nOps, 2);
    chkEq("R6 nak end op", opLog[1], 2'd3);
    chkEq("R6 nak event", nNak, 1);
    chkEq("R6 no ack", nAck, 0);
    chkEq("R6 nak status", cmdStatus, 32'h0040_0000);
  endtask

  task automatic t_stop();
    issue(16'h0020);
    chkEq("R8 stop ops", nOps, 1);
    chkEq("R8 stop op end", opLog[0], 2'd3);
    chkEq("R8 stop normal", nNorm, 1);
    chkEq("R8 stop status", cmdStatus, 32'h0);
  endtask

  task automatic t_abnormal();
    issue(16'h0020);
    chkEq("R8 abnormal busy", busyAfter, 1);
    chkEq("R8 abnormal ops", nOps, 0);
    chkEq("R8 abnormal event", nAbn, 1);
    chkEq("R8 abnormal status", cmdStatus, 32'h0);
  endtask

  task automatic t_addrNak();
    addrAckV = 1'b0;
    issue(16'h002B);
    addrAckV = 1'b1;
    chkEq("R5 ops", nOps, 1);
    chkEq("R5 nak event", nNak, 1);
    chkEq("R5 status", cmdStatus, 32'h0048_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0x0 exp=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    @(negedge clk); ctlWrEn = 1'b1; ctlMasterEn = 1'b1;
    @(negedge clk); ctlWrEn = 1'b0;
    t_chain();
    t_rxSkip();
    t_rxClr();
    t_restart();
    t_busyIgnore();
    t_txNak();
    t_stop();
    t_abnormal();
    t_addrNak();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule